// File: doc/BRIEF.md
# Byte-wide Handshake Host Link Endpoint

This block is the fabric-side end of a slow byte link driven by a host microcontroller. The link has one 8-bit inbound data port and one 8-bit outbound data port. The two ports work independently, so a byte can move in each direction at the same time. The host produces a link clock by toggling a pin in software. It also drives a reset line, a valid strobe for the bytes it sends and a ready strobe for the bytes it receives. The block answers with its own ready strobe for inbound bytes and its own valid strobe for outbound bytes.

All host-driven control lines pass through two-flop synchronizers into the fabric clock domain. The block acts only when it detects a rising edge of the synchronized link clock. Each such edge can complete at most one inbound byte and at most one outbound byte.

Toward user logic the block presents two byte streams, each with a valid/ready handshake. The pins shared with device configuration are kept undriven: their output enables are held off.

Top module: `hl_endpoint`

## Requirements
- R1: While the fabric reset is high, and while the synchronized host reset is high, the block holds the following state. Both holding registers read 0 on `rx_data` and `lnk_dout`, and `rx_valid`, `lnk_dev_vld` and `lnk_dev_rdy` are low. The host reset takes effect two fabric cycles after it is sampled high. `lnk_dev_rdy` rises on the first fabric edge after reset ends.
- R2: A detected link-clock rising edge captures `lnk_din` into the inbound holding register if, at that edge, `lnk_dev_rdy` and the synchronized `lnk_host_vld` are both high. After the capture, `rx_valid` is high, `rx_data` shows the byte and `lnk_dev_rdy` is low.
- R3: A link-clock edge has no effect on the inbound side when `lnk_dev_rdy` is low or the host valid strobe is low. In that case `rx_data` and `rx_valid` stay as they were.
- R4: `rx_valid` and `rx_data` hold until `rx_ready` is seen high. On that edge the byte is released, and `lnk_dev_rdy` is high from the next cycle.
- R5: `tx_ready` is high exactly when no outbound byte is held. On an edge with `tx_valid` and `tx_ready` both high, `tx_data` is loaded, and from the next cycle `lnk_dev_vld` is high with the byte on `lnk_dout`.
- R6: While `lnk_dev_vld` is high, `lnk_dout` does not change and new `tx_data` is not taken. `lnk_dev_vld` drops after a detected link-clock rising edge that comes with the synchronized `lnk_host_rdy` high.
- R7: A steady host ready level without a link-clock rising edge does not release the outbound byte.
- R8: An inbound and an outbound transfer can complete on the same link-clock edge, and neither affects the other.
- R9: A link-clock rise takes effect on the third fabric edge at which `lnk_clk` is sampled high, counting the first. A link-clock high phase, however long, counts as one edge.
- R10: `cfg_oe`, the output enables of the shared configuration pins, is all zeros at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Fabric synchronous reset, active high |
| lnk_clk | input | 1 | Software-toggled link clock from the host |
| lnk_rst | input | 1 | Host reset for the link logic, active high |
| lnk_din | input | 8 | Inbound data from the host |
| lnk_host_vld | input | 1 | Host has valid data on `lnk_din` |
| lnk_dev_rdy | output | 1 | Block can accept another inbound byte |
| lnk_dout | output | 8 | Outbound data to the host |
| lnk_dev_vld | output | 1 | Block has valid data on `lnk_dout` |
| lnk_host_rdy | input | 1 | Host can accept another outbound byte |
| rx_data | output | 8 | Inbound byte to user logic |
| rx_valid | output | 1 | Inbound byte is present |
| rx_ready | input | 1 | User logic takes the inbound byte |
| tx_data | input | 8 | Outbound byte from user logic |
| tx_valid | input | 1 | User logic offers an outbound byte |
| tx_ready | output | 1 | Outbound holding register is free |
| cfg_oe | output | 5 | Output enables of the shared configuration pins |

## Verification
The assertions check the following on every cycle:
- a qualified edge captures the inbound byte;
- the inbound ready and full states never overlap;
- held bytes stay stable in both directions until their handshake completes;
- the outbound byte is released on a qualified edge;
- the reset values;
- no rising edge is flagged on two cycles in a row.

Some behaviours only the bench scenarios can show, because they involve the synchronizer delay as seen from the pins. These are the exact three-edge latency and the fact that the host reset takes effect two cycles late. They also include the inbound byte being ignored while the block is full, and concurrent traffic in both directions over a stream of bytes.

// File: rtl/hl_pkg.sv
package hl_pkg;
  localparam int unsigned HL_BYTE_W     = 8;
  localparam int unsigned HL_SYNC_DEPTH = 2;
  localparam int unsigned HL_CFG_PINS   = 5;
  localparam int unsigned HL_NCTRL      = 4;
  localparam int unsigned HL_IDX_CLK    = 0;
  localparam int unsigned HL_IDX_HVLD   = 1;
  localparam int unsigned HL_IDX_HRDY   = 2;
  localparam int unsigned HL_IDX_RST    = 3;
endpackage

// File: rtl/hl_sync.sv
module hl_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int unsigned LAST = STAGES - 1;
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[LAST];
endmodule

// File: rtl/hl_edge.sv
module hl_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  // R9: one strobe per link-clock high phase
  p_single_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/hl_rx_path.sv
module hl_rx_path #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic         host_vld,
  input  logic [W-1:0] din,
  output logic         dev_rdy,
  output logic [W-1:0] data,
  output logic         valid,
  input  logic         ready
);
  logic [W-1:0] hold_q;
  logic         full_q;
  logic         rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      full_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else if (full_q) begin
      if (ready) begin
        full_q <= 1'b0;
        rdy_q  <= 1'b1;
      end
    end else if (rdy_q && strobe && host_vld) begin
      hold_q <= din;
      full_q <= 1'b1;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q  <= 1'b1;
    end
  end

  assign dev_rdy = rdy_q;
  assign data    = hold_q;
  assign valid   = full_q;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!full_q && !rdy_q && hold_q == '0));
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (rdy_q && strobe && host_vld) |=> (full_q && hold_q == $past(din)));
  p_rdy_excl_r2: assert property (@(posedge clk) disable iff (rst)
    rdy_q |-> !full_q);
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (full_q && !ready) |=> (full_q && $stable(hold_q)));
  p_rearm_r4: assert property (@(posedge clk) disable iff (rst)
    (full_q && ready) |=> (rdy_q && !full_q));
endmodule

// File: rtl/hl_tx_path.sv
module hl_tx_path #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic         host_rdy,
  output logic [W-1:0] dout,
  output logic         dev_vld,
  input  logic [W-1:0] data,
  input  logic         valid,
  output logic         ready
);
  logic [W-1:0] hold_q;
  logic         vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      vld_q  <= 1'b0;
    end else if (vld_q) begin
      if (strobe && host_rdy) vld_q <= 1'b0;
    end else if (valid) begin
      hold_q <= data;
      vld_q  <= 1'b1;
    end
  end

  assign dout    = hold_q;
  assign dev_vld = vld_q;
  assign ready   = ~vld_q;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!vld_q && hold_q == '0));
  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    (!vld_q && valid) |=> (vld_q && hold_q == $past(data)));
  p_keep_out_r6: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !(strobe && host_rdy)) |=> (vld_q && $stable(hold_q)));
  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    (vld_q && strobe && host_rdy) |=> !vld_q);
  p_no_edge_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !strobe) |=> vld_q);
endmodule

// File: rtl/hl_endpoint.sv
module hl_endpoint
  import hl_pkg::*;
#(
  parameter int unsigned BYTE_W     = HL_BYTE_W,
  parameter int unsigned SYNC_DEPTH = HL_SYNC_DEPTH,
  parameter int unsigned CFG_PINS   = HL_CFG_PINS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lnk_clk,
  input  logic              lnk_rst,
  input  logic [BYTE_W-1:0] lnk_din,
  input  logic              lnk_host_vld,
  output logic              lnk_dev_rdy,
  output logic [BYTE_W-1:0] lnk_dout,
  output logic              lnk_dev_vld,
  input  logic              lnk_host_rdy,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [CFG_PINS-1:0] cfg_oe
);
  logic [HL_NCTRL-1:0] ctrl_raw;
  logic [HL_NCTRL-1:0] ctrl_s;
  logic                clk_rise;
  logic                rst_i;

  always_comb begin
    ctrl_raw              = '0;
    ctrl_raw[HL_IDX_CLK]  = lnk_clk;
    ctrl_raw[HL_IDX_HVLD] = lnk_host_vld;
    ctrl_raw[HL_IDX_HRDY] = lnk_host_rdy;
    ctrl_raw[HL_IDX_RST]  = lnk_rst;
  end

  hl_sync #(.W(HL_NCTRL), .STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ctrl_raw),
    .q   (ctrl_s)
  );

  hl_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (ctrl_s[HL_IDX_CLK]),
    .rise (clk_rise)
  );

  assign rst_i = rst | ctrl_s[HL_IDX_RST];

  hl_rx_path #(.W(BYTE_W)) u_rx (
    .clk      (clk),
    .rst      (rst_i),
    .strobe   (clk_rise),
    .host_vld (ctrl_s[HL_IDX_HVLD]),
    .din      (lnk_din),
    .dev_rdy  (lnk_dev_rdy),
    .data     (rx_data),
    .valid    (rx_valid),
    .ready    (rx_ready)
  );

  hl_tx_path #(.W(BYTE_W)) u_tx (
    .clk      (clk),
    .rst      (rst_i),
    .strobe   (clk_rise),
    .host_rdy (ctrl_s[HL_IDX_HRDY]),
    .dout     (lnk_dout),
    .dev_vld  (lnk_dev_vld),
    .data     (tx_data),
    .valid    (tx_valid),
    .ready    (tx_ready)
  );

  assign cfg_oe = '0;
endmodule

// File: tb/hl_endpoint_bench.sv
module hl_endpoint_bench;
  localparam int unsigned CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lnk_clk = 1'b0, lnk_rst = 1'b0;
  logic [7:0] lnk_din = 8'h00;
  logic       lnk_host_vld = 1'b0, lnk_host_rdy = 1'b0;
  logic       lnk_dev_rdy, lnk_dev_vld;
  logic [7:0] lnk_dout, rx_data;
  logic       rx_valid, tx_ready;
  logic       rx_ready = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic [4:0] cfg_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit run   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hl_endpoint u_hl_endpoint (
    .clk(clk), .rst(rst), .lnk_clk(lnk_clk), .lnk_rst(lnk_rst),
    .lnk_din(lnk_din), .lnk_host_vld(lnk_host_vld), .lnk_dev_rdy(lnk_dev_rdy),
    .lnk_dout(lnk_dout), .lnk_dev_vld(lnk_dev_vld), .lnk_host_rdy(lnk_host_rdy),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .cfg_oe(cfg_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: sampled histories of host pins and transfer state
  bit c1, c2, c3, v1, v2, v3, r1, r2, r3, h1, h2, h3;
  bit m_full, m_rdy, m_vld, m_rise;
  bit [7:0] m_rxd, m_txd;

  always @(posedge clk) begin
    m_rise = c2 && !c3;
    if (rst || h2) begin
      m_full = 0; m_rdy = 0; m_vld = 0; m_rxd = 0; m_txd = 0;
    end else begin
      if (m_full) begin
        if (rx_ready) begin m_full = 0; m_rdy = 1; end
      end else if (m_rdy && m_rise && v2) begin
        m_rxd = lnk_din; m_full = 1; m_rdy = 0;
      end else begin
        m_rdy = 1;
      end
      if (m_vld) begin
        if (m_rise && r2) m_vld = 0;
      end else if (tx_valid) begin
        m_txd = tx_data; m_vld = 1;
      end
    end
    if (rst) begin
      {c1, c2, c3, v1, v2, v3, r1, r2, r3, h1, h2, h3} = '0;
    end else begin
      c3 = c2; c2 = c1; c1 = lnk_clk;
      v3 = v2; v2 = v1; v1 = lnk_host_vld;
      r3 = r2; r2 = r1; r1 = lnk_host_rdy;
      h3 = h2; h2 = h1; h1 = lnk_rst;
    end
    run = 1'b1;
  end

  always @(negedge clk) begin
    if (run && !done) begin
      chk("R2 rx_valid", rx_valid, m_full);
      chk("R2 rx_data", rx_data, m_rxd);
      chk("R4 lnk_dev_rdy", lnk_dev_rdy, m_rdy);
      chk("R6 lnk_dev_vld", lnk_dev_vld, m_vld);
      chk("R6 lnk_dout", lnk_dout, m_txd);
      chk("R5 tx_ready", tx_ready, !m_vld);
      chk("R10 cfg_oe", cfg_oe, 0);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lclk_pulse();
    lnk_clk = 1'b1;
    wait_n(6);
    lnk_clk = 1'b0;
    wait_n(6);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    wait_n(4);
    chk("R1 dev_rdy in reset", lnk_dev_rdy, 0);
    chk("R1 rx_valid in reset", rx_valid, 0);
    chk("R1 dev_vld in reset", lnk_dev_vld, 0);
    rst = 1'b0;
    wait_n(1);
    chk("R1 dev_rdy after reset", lnk_dev_rdy, 1);
    chk("R10 cfg_oe zero", cfg_oe, 0);

    // R9 latency and R2 capture
    lnk_din = 8'hA5; lnk_host_vld = 1'b1; lnk_clk = 1'b1;
    wait_n(2);
    chk("R9 not yet captured", rx_valid, 0);
    wait_n(1);
    chk("R9 captured on third edge", rx_valid, 1);
    chk("R2 rx_data", rx_data, 8'hA5);
    chk("R2 dev_rdy low", lnk_dev_rdy, 0);
    wait_n(3);
    lnk_clk = 1'b0;
    wait_n(6);

    // R3 byte offered while full is ignored
    lnk_din = 8'h5A;
    lclk_pulse();
    chk("R3 rx_data kept", rx_data, 8'hA5);
    lnk_host_vld = 1'b0;

    // R4 release
    rx_ready = 1'b1;
    wait_n(1);
    rx_ready = 1'b0;
    wait_n(1);
    chk("R4 rx_valid cleared", rx_valid, 0);
    chk("R4 dev_rdy back", lnk_dev_rdy, 1);

    // R3 edge without host valid
    lnk_din = 8'hFF;
    lclk_pulse();
    chk("R3 no capture w/o valid", rx_valid, 0);

    // R5 load
    chk("R5 tx_ready idle", tx_ready, 1);
    tx_data = 8'h3C; tx_valid = 1'b1;
    wait_n(1);
    tx_valid = 1'b0;
    chk("R5 dev_vld", lnk_dev_vld, 1);
    chk("R5 dout", lnk_dout, 8'h3C);
    chk("R5 tx_ready busy", tx_ready, 0);

    // R7 host ready level without edge
    lnk_host_rdy = 1'b1;
    wait_n(10);
    chk("R7 dev_vld held", lnk_dev_vld, 1);
    tx_data = 8'h99; tx_valid = 1'b1;
    wait_n(1);
    tx_valid = 1'b0;
    chk("R6 dout stable", lnk_dout, 8'h3C);
    lclk_pulse();
    chk("R6 dev_vld released", lnk_dev_vld, 0);
    lnk_host_rdy = 1'b0;

    // R8 both directions on one edge
    tx_data = 8'h81; tx_valid = 1'b1;
    wait_n(1);
    tx_valid = 1'b0;
    lnk_din = 8'h42; lnk_host_vld = 1'b1; lnk_host_rdy = 1'b1;
    lclk_pulse();
    chk("R8 rx_data", rx_data, 8'h42);
    chk("R8 rx_valid", rx_valid, 1);
    chk("R8 dev_vld released", lnk_dev_vld, 0);
    lnk_host_vld = 1'b0; lnk_host_rdy = 1'b0;

    // R1 host reset with both sides holding bytes
    tx_data = 8'h77; tx_valid = 1'b1;
    wait_n(1);
    tx_valid = 1'b0;
    lnk_rst = 1'b1;
    wait_n(3);
    chk("R1 host rst rx_valid", rx_valid, 0);
    chk("R1 host rst rx_data", rx_data, 0);
    chk("R1 host rst dev_vld", lnk_dev_vld, 0);
    chk("R1 host rst dout", lnk_dout, 0);
    chk("R1 host rst dev_rdy", lnk_dev_rdy, 0);
    lnk_rst = 1'b0;
    wait_n(4);
    chk("R1 dev_rdy after host rst", lnk_dev_rdy, 1);

    // Streaming in both directions, checked by the reference every cycle
    rx_ready = 1'b1; lnk_host_rdy = 1'b1; lnk_host_vld = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tx_data = 8'(i * 37 + 5); tx_valid = 1'b1;
      lnk_din = ~8'(i);
      lclk_pulse();
    end
    tx_valid = 1'b0; lnk_host_vld = 1'b0;
    wait_n(8);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule